// File: doc/BRIEF.md
# Command/Address Register Buffer with Parity Check

This block sits between a memory controller and four ranks of DDR3 devices. On every rising clock edge it captures the controller's address, bank, command strobes, four rank selects, two clock-enable lines, two termination-enable lines and a parity bit. It presents the captured values to the ranks one cycle later. It fans each clock-enable and termination-enable line out to a pair of ranks.

The block checks even parity over the captured address, bank and command strobes in every cycle that selects at least one rank. A failed check pulls an active-low error flag low for two clocks. A DRAM command with bad parity still goes to the ranks unchanged. A cycle that selects all four ranks at once is a write to a bank of 64 four-bit internal control words. That cycle is not passed to the ranks, and the write is dropped when its parity is bad. The control words drive a flat configuration output for neighbouring logic.

The error flag comes from a three-state machine. ERR_IDLE holds the flag high. The machine moves from any state to ERR_HOLD1 when the captured word fails its check. It moves from ERR_HOLD1 to ERR_HOLD2 on a clean cycle, and from ERR_HOLD2 back to ERR_IDLE on a clean cycle. The flag is low in both hold states.

Top module: `ca_reg_buffer`

## Requirements
- R1: Address, bank and the three command strobes driven before a rising edge appear on the rank-side outputs after that edge.
- R2: Parity is good when the 16 address bits, 3 bank bits, the three command strobes and the parity input together hold an even number of ones. An odd count in a cycle with at least one select low is an error.
- R3: After a faulty word is captured, the error output goes low after the next rising edge. It stays low for exactly two clock cycles and then returns high.
- R4: A cycle with all four selects high never causes an error, whatever its parity.
- R5: A DRAM command with bad parity is forwarded to the ranks unchanged, including its rank selects.
- R6: A cycle with all four selects low is a control-word write. Its index is {bank[2:0], addr[2:0]} and its data is addr[7:4]. The word shows at cfg_words[4*index+3 : 4*index] after the second rising edge. In the cycle after capture, the rank selects all read high.
- R7: A control-word write with bad parity leaves every control word unchanged.
- R8: Clock-enable line 0 drives ranks 0 and 2. Line 1 drives ranks 1 and 3. Bit r of rank_cke is rank r.
- R9: Termination line 0 drives ranks 0 and 1. Line 1 drives ranks 2 and 3. Bit r of rank_odt is rank r.
- R10: While rst_n is low, the selects and command strobes read high, address, bank, clock-enable and termination outputs read zero, the error output reads high and every control word reads zero.
- R11: A faulty capture while the error output is already low restarts the two-cycle window from that capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 16 | Address from controller |
| host_bank | input | 3 | Bank address from controller |
| host_ras_n | input | 1 | Row strobe, active low |
| host_cas_n | input | 1 | Column strobe, active low |
| host_we_n | input | 1 | Write strobe, active low |
| host_cs_n | input | 4 | Rank selects, active low |
| host_cke | input | 2 | Clock-enable lines |
| host_odt | input | 2 | Termination-enable lines |
| host_par | input | 1 | Even parity bit |
| rank_addr | output | 16 | Registered address |
| rank_bank | output | 3 | Registered bank |
| rank_ras_n | output | 1 | Registered row strobe |
| rank_cas_n | output | 1 | Registered column strobe |
| rank_we_n | output | 1 | Registered write strobe |
| rank_cs_n | output | 4 | Registered selects, all high for a control-word write |
| rank_cke | output | 4 | Per-rank clock enable |
| rank_odt | output | 4 | Per-rank termination enable |
| par_err_n | output | 1 | Parity error flag, active low |
| cfg_words | output | 256 | 64 control words, four bits each |

## Verification
The error window and the control-word commit can fall in the same cycle. The bench provokes this by sending a DRAM command with bad parity and then a good control-word write on the next cycle, so the write lands while the flag is low. The bench judges the word contents and the flag independently, each against its own scheduled expectation. It also sends a bad-parity control-word write inside a live error window. That write must restart the window and must leave the words untouched.

// File: rtl/ca_buf_pkg.sv
package ca_buf_pkg;
    localparam int DEF_ADDR_W      = 16;
    localparam int DEF_BANK_W      = 3;
    localparam int DEF_RANK_N      = 4;
    localparam int DEF_CKE_N       = 2;
    localparam int DEF_ODT_N       = 2;
    localparam int DEF_CW_SEL_LO   = 3;
    localparam int DEF_CW_DATA_LSB = 4;
    localparam int DEF_CW_DATA_W   = 4;

    typedef enum logic [1:0] {
        ERR_IDLE  = 2'd0,
        ERR_HOLD1 = 2'd1,
        ERR_HOLD2 = 2'd2
    } err_state_t;
endpackage

// File: rtl/ca_capture.sv
module ca_capture #(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 3,
    parameter int RANK_N = 4,
    parameter int CKE_N  = 2,
    parameter int ODT_N  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [BANK_W-1:0] in_bank,
    input  logic              in_ras_n,
    input  logic              in_cas_n,
    input  logic              in_we_n,
    input  logic [RANK_N-1:0] in_cs_n,
    input  logic [CKE_N-1:0]  in_cke,
    input  logic [ODT_N-1:0]  in_odt,
    input  logic              in_par,
    output logic [ADDR_W-1:0] q_addr,
    output logic [BANK_W-1:0] q_bank,
    output logic              q_ras_n,
    output logic              q_cas_n,
    output logic              q_we_n,
    output logic [RANK_N-1:0] q_cs_n,
    output logic [RANK_N-1:0] q_cke,
    output logic [RANK_N-1:0] q_odt,
    output logic              q_par,
    output logic              q_sel_any,
    output logic              q_cw_hit
);
    localparam int ODT_GRP = RANK_N / ODT_N;

    logic [RANK_N-1:0] cke_fan;
    logic [RANK_N-1:0] odt_fan;
    logic              cw_hit;

    // Rank fan-out: clock enables interleave, terminations group in pairs
    for (genvar r = 0; r < RANK_N; r++) begin : g_fan
        assign cke_fan[r] = in_cke[r % CKE_N];
        assign odt_fan[r] = in_odt[r / ODT_GRP];
    end

    assign cw_hit = ~|in_cs_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_addr    <= '0;
            q_bank    <= '0;
            q_ras_n   <= 1'b1;
            q_cas_n   <= 1'b1;
            q_we_n    <= 1'b1;
            q_cs_n    <= '1;
            q_cke     <= '0;
            q_odt     <= '0;
            q_par     <= 1'b0;
            q_sel_any <= 1'b0;
            q_cw_hit  <= 1'b0;
        end else begin
            q_addr    <= in_addr;
            q_bank    <= in_bank;
            q_ras_n   <= in_ras_n;
            q_cas_n   <= in_cas_n;
            q_we_n    <= in_we_n;
            q_cs_n    <= cw_hit ? '1 : in_cs_n;
            q_cke     <= cke_fan;
            q_odt     <= odt_fan;
            q_par     <= in_par;
            q_sel_any <= ~&in_cs_n;
            q_cw_hit  <= cw_hit;
        end
    end
endmodule

// File: rtl/ca_parity_chk.sv
module ca_parity_chk
    import ca_buf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] bank,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              par,
    input  logic              sel_any,
    output logic              bad,
    output logic              err_n
);
    err_state_t state_q, state_d;

    assign bad = sel_any & (^{addr, bank, ras_n, cas_n, we_n, par});

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ERR_IDLE:  state_d = bad ? ERR_HOLD1 : ERR_IDLE;
            ERR_HOLD1: state_d = bad ? ERR_HOLD1 : ERR_HOLD2;
            ERR_HOLD2: state_d = bad ? ERR_HOLD1 : ERR_IDLE;
            default:   state_d = ERR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ERR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        err_n = (state_q == ERR_IDLE);
    end

    p_bad_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> !err_n);
    p_low_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_n) |=> !err_n);
    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ERR_HOLD2 && !bad) |=> err_n);
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ERR_IDLE && !sel_any) |=> err_n);
    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ERR_HOLD2 && bad) |=> (state_q == ERR_HOLD1));
endmodule

// File: rtl/ca_ctrl_words.sv
module ca_ctrl_words #(
    parameter int IDX_W  = 6,
    parameter int DATA_W = 4,
    parameter int NUM    = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_req,
    input  logic                  wr_block,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [NUM*DATA_W-1:0] words_flat
);
    logic wr_ok;
    assign wr_ok = wr_req & ~wr_block;

    for (genvar i = 0; i < NUM; i++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 word_q <= '0;
            else if (wr_ok && (wr_idx == IDX_W'(i)))    word_q <= wr_data;
        end
        assign words_flat[i*DATA_W +: DATA_W] = word_q;
    end

    p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_block) |=>
            (words_flat[int'($past(wr_idx))*DATA_W +: DATA_W] == $past(wr_data)));
    p_blocked_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_block) |=> $stable(words_flat));
endmodule

// File: rtl/ca_reg_buffer.sv
module ca_reg_buffer
    import ca_buf_pkg::*;
#(
    parameter int ADDR_W      = DEF_ADDR_W,
    parameter int BANK_W      = DEF_BANK_W,
    parameter int RANK_N      = DEF_RANK_N,
    parameter int CKE_N       = DEF_CKE_N,
    parameter int ODT_N       = DEF_ODT_N,
    parameter int CW_SEL_LO   = DEF_CW_SEL_LO,
    parameter int CW_DATA_LSB = DEF_CW_DATA_LSB,
    parameter int CW_DATA_W   = DEF_CW_DATA_W,
    localparam int CW_IDX_W   = BANK_W + CW_SEL_LO,
    localparam int CW_NUM     = 1 << CW_IDX_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         host_addr,
    input  logic [BANK_W-1:0]         host_bank,
    input  logic                      host_ras_n,
    input  logic                      host_cas_n,
    input  logic                      host_we_n,
    input  logic [RANK_N-1:0]         host_cs_n,
    input  logic [CKE_N-1:0]          host_cke,
    input  logic [ODT_N-1:0]          host_odt,
    input  logic                      host_par,
    output logic [ADDR_W-1:0]         rank_addr,
    output logic [BANK_W-1:0]         rank_bank,
    output logic                      rank_ras_n,
    output logic                      rank_cas_n,
    output logic                      rank_we_n,
    output logic [RANK_N-1:0]         rank_cs_n,
    output logic [RANK_N-1:0]         rank_cke,
    output logic [RANK_N-1:0]         rank_odt,
    output logic                      par_err_n,
    output logic [CW_NUM*CW_DATA_W-1:0] cfg_words
);
    logic cap_par, cap_sel_any, cap_cw_hit, cap_bad;

    ca_capture #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .RANK_N(RANK_N),
        .CKE_N(CKE_N), .ODT_N(ODT_N)
    ) u_capture (
        .clk(clk), .rst_n(rst_n),
        .in_addr(host_addr), .in_bank(host_bank),
        .in_ras_n(host_ras_n), .in_cas_n(host_cas_n), .in_we_n(host_we_n),
        .in_cs_n(host_cs_n), .in_cke(host_cke), .in_odt(host_odt),
        .in_par(host_par),
        .q_addr(rank_addr), .q_bank(rank_bank),
        .q_ras_n(rank_ras_n), .q_cas_n(rank_cas_n), .q_we_n(rank_we_n),
        .q_cs_n(rank_cs_n), .q_cke(rank_cke), .q_odt(rank_odt),
        .q_par(cap_par), .q_sel_any(cap_sel_any), .q_cw_hit(cap_cw_hit)
    );

    ca_parity_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_parity (
        .clk(clk), .rst_n(rst_n),
        .addr(rank_addr), .bank(rank_bank),
        .ras_n(rank_ras_n), .cas_n(rank_cas_n), .we_n(rank_we_n),
        .par(cap_par), .sel_any(cap_sel_any),
        .bad(cap_bad), .err_n(par_err_n)
    );

    ca_ctrl_words #(.IDX_W(CW_IDX_W), .DATA_W(CW_DATA_W), .NUM(CW_NUM)) u_words (
        .clk(clk), .rst_n(rst_n),
        .wr_req(cap_cw_hit), .wr_block(cap_bad),
        .wr_idx({rank_bank, rank_addr[CW_SEL_LO-1:0]}),
        .wr_data(rank_addr[CW_DATA_LSB +: CW_DATA_W]),
        .words_flat(cfg_words)
    );

    p_addr_through_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rank_addr == $past(host_addr) && rank_bank == $past(host_bank)));
    p_cw_not_sent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (~|host_cs_n) |=> (&rank_cs_n));
    p_cmd_sent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|host_cs_n) |=> (rank_cs_n == $past(host_cs_n)));
endmodule

// File: tb/ca_reg_buffer_test.sv
module ca_reg_buffer_test;
    localparam int CLK_NS = 10;

    logic clk = 1'b0;
    always #(CLK_NS/2) clk = ~clk;

    logic         rst_n;
    logic [15:0]  host_addr;
    logic [2:0]   host_bank;
    logic         host_ras_n, host_cas_n, host_we_n;
    logic [3:0]   host_cs_n;
    logic [1:0]   host_cke, host_odt;
    logic         host_par;
    logic [15:0]  rank_addr;
    logic [2:0]   rank_bank;
    logic         rank_ras_n, rank_cas_n, rank_we_n;
    logic [3:0]   rank_cs_n, rank_cke, rank_odt;
    logic         par_err_n;
    logic [255:0] cfg_words;

    ca_reg_buffer uut (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_bank(host_bank),
        .host_ras_n(host_ras_n), .host_cas_n(host_cas_n), .host_we_n(host_we_n),
        .host_cs_n(host_cs_n), .host_cke(host_cke), .host_odt(host_odt),
        .host_par(host_par),
        .rank_addr(rank_addr), .rank_bank(rank_bank),
        .rank_ras_n(rank_ras_n), .rank_cas_n(rank_cas_n), .rank_we_n(rank_we_n),
        .rank_cs_n(rank_cs_n), .rank_cke(rank_cke), .rank_odt(rank_odt),
        .par_err_n(par_err_n), .cfg_words(cfg_words)
    );

    typedef struct {
        int unsigned tgt;
        logic [15:0] a;
        logic [2:0]  b;
        logic [2:0]  cmd;
        logic [3:0]  cs, cke, odt;
    } exp_t;
    typedef struct {
        int unsigned tgt;
        int          idx;
        logic [3:0]  d;
    } cwu_t;

    exp_t        fq[$];
    cwu_t        cq[$];
    logic [3:0]  model [64];
    bit          err_sched [4096];
    int unsigned cyc = 0;
    int          checks = 0, fails = 0;
    bit          mon_on = 1'b0, done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
        end
    endtask

    // Monitor: compares outputs against scheduled expectations
    always @(negedge clk) begin
        logic [255:0] e;
        exp_t x;
        if (mon_on) begin
            while (cq.size() > 0 && cq[0].tgt <= cyc) begin
                model[cq[0].idx] = cq[0].d;
                void'(cq.pop_front());
            end
            for (int i = 0; i < 64; i++) e[i*4 +: 4] = model[i];
            chk("R6/R7 control words", cfg_words, e);
            chk("R2/R3/R4/R11 error flag", 256'(par_err_n), 256'(!err_sched[cyc % 4096]));
            err_sched[cyc % 4096] = 1'b0;
            if (fq.size() > 0 && fq[0].tgt == cyc) begin
                x = fq.pop_front();
                chk("R1/R5 address", 256'(rank_addr), 256'(x.a));
                chk("R1/R5 bank", 256'(rank_bank), 256'(x.b));
                chk("R1/R5 strobes", 256'({rank_ras_n, rank_cas_n, rank_we_n}), 256'(x.cmd));
                chk("R5/R6 selects", 256'(rank_cs_n), 256'(x.cs));
                chk("R8 clock enables", 256'(rank_cke), 256'(x.cke));
                chk("R9 terminations", 256'(rank_odt), 256'(x.odt));
            end
        end
    end

    // Driver: drives one cycle and pushes its expected results
    task automatic apply(logic [15:0] a, logic [2:0] b, logic [2:0] cmd,
                         logic [3:0] cs, logic [1:0] cke, logic [1:0] odt, bit good);
        int unsigned n;
        exp_t x;
        cwu_t u;
        logic p;
        @(negedge clk);
        n = cyc;
        p = ^{a, b, cmd};
        host_addr = a; host_bank = b;
        {host_ras_n, host_cas_n, host_we_n} = cmd;
        host_cs_n = cs; host_cke = cke; host_odt = odt;
        host_par = good ? p : ~p;
        x.tgt = n + 1; x.a = a; x.b = b; x.cmd = cmd;
        x.cs  = (cs == 4'h0) ? 4'hF : cs;
        x.cke = {cke[1], cke[0], cke[1], cke[0]};
        x.odt = {odt[1], odt[1], odt[0], odt[0]};
        fq.push_back(x);
        if (cs != 4'hF && !good) begin
            err_sched[(n + 2) % 4096] = 1'b1;
            err_sched[(n + 3) % 4096] = 1'b1;
        end
        if (cs == 4'h0 && good) begin
            u.tgt = n + 2; u.idx = int'({b, a[2:0]}); u.d = a[7:4];
            cq.push_back(u);
        end
    endtask

    task automatic idle(int k);
        for (int i = 0; i < k; i++) apply(16'h0, 3'h0, 3'b111, 4'hF, 2'b00, 2'b00, 1'b1);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired at cycle %0d: actual=hung expected=done", cyc);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = 4'h0;
        for (int i = 0; i < 4096; i++) err_sched[i] = 1'b0;
        rst_n = 1'b0;
        host_addr = 16'hFFFF; host_bank = 3'h7;
        {host_ras_n, host_cas_n, host_we_n} = 3'b000;
        host_cs_n = 4'h0; host_cke = 2'b11; host_odt = 2'b11; host_par = 1'b1;
        repeat (3) @(negedge clk);
        // R10: reset state while rst_n is low
        chk("R10 selects", 256'(rank_cs_n), 256'(4'hF));
        chk("R10 strobes", 256'({rank_ras_n, rank_cas_n, rank_we_n}), 256'(3'b111));
        chk("R10 address", 256'(rank_addr), 256'(0));
        chk("R10 cke/odt", 256'({rank_cke, rank_odt}), 256'(0));
        chk("R10 error flag", 256'(par_err_n), 256'(1));
        chk("R10 control words", cfg_words, 256'(0));
        host_cs_n = 4'hF;
        rst_n = 1'b1;
        mon_on = 1'b1;
        idle(2);

        // R1/R8/R9: good commands with distinct patterns
        apply(16'h1234, 3'h5, 3'b011, 4'b1110, 2'b01, 2'b10, 1'b1);
        apply(16'hA5C3, 3'h2, 3'b101, 4'b1101, 2'b10, 2'b01, 1'b1);
        apply(16'hFFFF, 3'h7, 3'b110, 4'b1011, 2'b11, 2'b00, 1'b1);
        idle(4);
        // R5/R2: bad-parity DRAM command still forwarded
        apply(16'h0F0F, 3'h1, 3'b001, 4'b0111, 2'b11, 2'b11, 1'b0);
        idle(5);
        // R4: idle cycle with wrong parity raises nothing
        apply(16'h00FF, 3'h3, 3'b111, 4'hF, 2'b00, 2'b00, 1'b0);
        idle(4);
        // R6: control-word writes at lowest, highest and a middle index
        apply(16'h0050, 3'h0, 3'b000, 4'h0, 2'b00, 2'b00, 1'b1);
        apply(16'h00A7, 3'h7, 3'b000, 4'h0, 2'b00, 2'b00, 1'b1);
        apply(16'h0035, 3'h4, 3'b000, 4'h0, 2'b00, 2'b00, 1'b1);
        idle(3);
        // R7: bad-parity write to index 37 is dropped
        apply(16'h00F5, 3'h4, 3'b000, 4'h0, 2'b00, 2'b00, 1'b0);
        idle(5);
        // R11: back-to-back faults extend the window
        apply(16'h8001, 3'h0, 3'b011, 4'b1110, 2'b01, 2'b01, 1'b0);
        apply(16'h8002, 3'h0, 3'b011, 4'b1101, 2'b01, 2'b01, 1'b0);
        idle(5);
        // Overlap: good write commits while error window is live
        apply(16'h4444, 3'h2, 3'b100, 4'b1110, 2'b10, 2'b10, 1'b0);
        apply(16'h0092, 3'h1, 3'b000, 4'h0, 2'b00, 2'b00, 1'b1);
        apply(16'h00E2, 3'h1, 3'b000, 4'h0, 2'b00, 2'b00, 1'b0);
        idle(5);
        // Mixed traffic
        for (int i = 0; i < 300; i++) begin
            logic [3:0] cs;
            cs = ($urandom % 5 == 0) ? 4'h0 : 4'($urandom);
            apply(16'($urandom), 3'($urandom), 3'($urandom), cs,
                  2'($urandom), 2'($urandom), ($urandom % 4) != 0);
        end
        idle(6);
        mon_on = 1'b0;
        done = 1'b1;
        finish_run();
    end
endmodule